// File: doc/BRIEF.md
# Segmented Address Translation Front End

This block sits between a processor's load/store and fetch paths and its paged translation lookaside buffers. For each access it takes a 32-bit virtual address, an access kind and a user-mode flag, and settles how the address is translated. If translation is switched off, the address passes through unchanged. If the access comes from supervisor mode and its segment is marked for direct mapping, a 4-bit base value taken from one of two kernel base registers replaces the top four address bits. Any other access becomes a lookup request to either the instruction TLB or the data TLB. The lookup answer is then returned as the result.

Requests and results each use a valid/ready handshake. The block holds one access at a time. It takes a new request only when it has no lookup outstanding and no result waiting. Back-pressure works as follows. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A result stays on the outputs, unchanged, until `res_ready` is seen high. A lookup request stays asserted, unchanged, until `tlb_req_ready` is seen high. The configuration inputs are sampled in the cycle the request is taken.

Top module: `seg_xlate_front`

## Requirements
- R1: `req_ready` is high exactly when the block holds no access: no result is pending and no lookup is outstanding. A request is taken on an edge where `req_valid` and `req_ready` are both high.
- R2: When `cfg_global` bits 2 and 3 are both clear, a taken request produces, on the next cycle, `res_valid` with `res_paddr` equal to the virtual address, `res_perm` = 3'b111 and `res_miss` = 0. No lookup request is issued.
- R3: Either bit 2 alone or bit 3 alone of `cfg_global` enables translation. The other bits of that register have no effect.
- R4: The segment number is `req_vaddr[31:28]`. A supervisor access (`req_user` = 0) with translation enabled and `cfg_mmu_seg[segment]` set is direct-mapped.
- R5: A direct-mapped access produces, on the next cycle, a result whose `res_paddr` is {base, `req_vaddr[27:0]`}. The base is the 4-bit field at bit (segment mod 8)×4 of `kbase_lo` for segments 0–7, and of `kbase_hi` for segments 8–15. The result also has `res_perm` = 3'b111 and `res_miss` = 0.
- R6: A user access with translation enabled always becomes a lookup request, whatever the setting of `cfg_mmu_seg`. A supervisor access whose segment bit is clear also becomes a lookup request.
- R7: Access kinds are encoded 0 = read, 1 = write, 2 = execute and 3 = treated as read. A lookup request asserts `tlb_req_valid` on the cycle after the request is taken. It carries the virtual address and user flag unchanged. It sets `tlb_req_itlb` = 1 only for kind 2. It forwards kind 3 as 0 and any other kind as given.
- R8: While a lookup is outstanding, the cycle after `tlb_rsp_valid` the block presents `tlb_rsp_paddr`, `tlb_rsp_perm` and `tlb_rsp_miss` as the result. A `tlb_rsp_valid` pulse arriving when no lookup is outstanding is ignored.
- R9: While `res_valid` is high and `res_ready` is low, the result stays valid and unchanged. While `tlb_req_valid` is high and `tlb_req_ready` is low, the lookup request stays valid and unchanged.
- R10: After reset, `req_ready` = 1, `res_valid` = 0 and `tlb_req_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Block can take a request |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 read |
| req_user | input | 1 | Access comes from user mode |
| cfg_global | input | 32 | Global configuration; bit 2 or bit 3 enables translation |
| cfg_mmu_seg | input | 16 | Per-segment direct-map enables |
| kbase_lo | input | 32 | Base fields for segments 0–7 |
| kbase_hi | input | 32 | Base fields for segments 8–15 |
| tlb_req_valid | output | 1 | Lookup request valid |
| tlb_req_ready | input | 1 | TLB takes the lookup |
| tlb_req_itlb | output | 1 | 1 = instruction TLB, 0 = data TLB |
| tlb_req_vaddr | output | 32 | Lookup virtual address |
| tlb_req_kind | output | 2 | Normalized access kind |
| tlb_req_user | output | 1 | Lookup is for a user access |
| tlb_rsp_valid | input | 1 | Lookup answer valid |
| tlb_rsp_paddr | input | 32 | Lookup physical address |
| tlb_rsp_perm | input | 3 | Lookup permissions {exec, write, read} |
| tlb_rsp_miss | input | 1 | Lookup missed or faulted |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_paddr | output | 32 | Physical address |
| res_perm | output | 3 | Permissions {exec, write, read} |
| res_miss | output | 1 | Miss reported |

## Verification
The bench walks all sixteen segments with distinct base fields in both kernel registers. A swapped register half or a wrong field offset therefore shows up as a wrong top nibble. It enables translation with bit 2 alone, with bit 3 alone, and with neither, using noise in the other bits. A design decoding the wrong bits would pass addresses through, or start lookups, when it should not. User accesses with every segment-enable bit set must still reach the TLB, and kind 3 must arrive at the data TLB as a read. A wrong routing choice appears as an unexpected lookup or a missing one. Back-pressure on both outputs, and a stray lookup answer sent while the block is idle, expose results that change while held, are dropped, or appear without a request.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_RSV = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    ROUTE_FLAT = 2'd0,
    ROUTE_SEG  = 2'd1,
    ROUTE_TLB  = 2'd2
  } route_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TREQ  = 2'd1,
    ST_TWAIT = 2'd2,
    ST_RESP  = 2'd3
  } xl_state_e;

  localparam int PERM_W = 3;
  localparam logic [PERM_W-1:0] PERM_ALL = 3'b111;

endpackage

// File: rtl/seg_base_mux.sv
module seg_base_mux #(
  parameter int SEG_BITS = 4,
  parameter int KB_W     = ((1 << SEG_BITS) / 2) * SEG_BITS
) (
  input  logic [SEG_BITS-1:0] seg,
  input  logic [KB_W-1:0]     base_lo,
  input  logic [KB_W-1:0]     base_hi,
  output logic [SEG_BITS-1:0] nib
);
  localparam int NSEG = 1 << SEG_BITS;
  localparam int HALF = NSEG / 2;

  logic [SEG_BITS-1:0] tbl [NSEG];

  // Lower half of the segments reads the low register, upper half the high one
  for (genvar g = 0; g < HALF; g++) begin : g_nib
    assign tbl[g]        = base_lo[g*SEG_BITS +: SEG_BITS];
    assign tbl[g + HALF] = base_hi[g*SEG_BITS +: SEG_BITS];
  end

  assign nib = tbl[seg];
endmodule

// File: rtl/seg_route_decode.sv
module seg_route_decode
  import seg_xlate_pkg::*;
#(
  parameter int AW       = 32,
  parameter int SEG_BITS = 4,
  parameter int REG_W    = 32,
  parameter int KB_W     = ((1 << SEG_BITS) / 2) * SEG_BITS,
  parameter logic [REG_W-1:0] EN_MASK = 'hC
) (
  input  logic [AW-1:0]              vaddr,
  input  logic [1:0]                 kind,
  input  logic                       user,
  input  logic [REG_W-1:0]           cfg_global,
  input  logic [(1<<SEG_BITS)-1:0]   seg_en,
  input  logic [KB_W-1:0]            kb_lo,
  input  logic [KB_W-1:0]            kb_hi,
  output route_e                     route,
  output logic [AW-1:0]              seg_paddr,
  output logic                       itlb,
  output logic [1:0]                 fwd_kind
);
  localparam int OFF_W = AW - SEG_BITS;

  logic [SEG_BITS-1:0] seg;
  logic [SEG_BITS-1:0] nib;
  logic                xl_on;

  assign seg   = vaddr[AW-1 -: SEG_BITS];
  assign xl_on = |(cfg_global & EN_MASK);

  seg_base_mux #(
    .SEG_BITS (SEG_BITS),
    .KB_W     (KB_W)
  ) u_base (
    .seg     (seg),
    .base_lo (kb_lo),
    .base_hi (kb_hi),
    .nib     (nib)
  );

  // Direct mapping is a supervisor-only shortcut taken before any TLB lookup
  always_comb begin
    if (!xl_on)                  route = ROUTE_FLAT;
    else if (!user && seg_en[seg]) route = ROUTE_SEG;
    else                         route = ROUTE_TLB;
  end

  assign seg_paddr = {nib, vaddr[OFF_W-1:0]};
  assign itlb      = (kind == ACC_EX);
  assign fwd_kind  = (kind == ACC_RSV) ? ACC_RD : kind;
endmodule

// File: rtl/seg_xlate_front.sv
module seg_xlate_front
  import seg_xlate_pkg::*;
#(
  parameter int AW       = 32,
  parameter int SEG_BITS = 4,
  parameter int REG_W    = 32,
  parameter int KB_W     = ((1 << SEG_BITS) / 2) * SEG_BITS,
  parameter logic [REG_W-1:0] EN_MASK = 'hC
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [AW-1:0]             req_vaddr,
  input  logic [1:0]                req_kind,
  input  logic                      req_user,
  input  logic [REG_W-1:0]          cfg_global,
  input  logic [(1<<SEG_BITS)-1:0]  cfg_mmu_seg,
  input  logic [KB_W-1:0]           kbase_lo,
  input  logic [KB_W-1:0]           kbase_hi,
  output logic                      tlb_req_valid,
  input  logic                      tlb_req_ready,
  output logic                      tlb_req_itlb,
  output logic [AW-1:0]             tlb_req_vaddr,
  output logic [1:0]                tlb_req_kind,
  output logic                      tlb_req_user,
  input  logic                      tlb_rsp_valid,
  input  logic [AW-1:0]             tlb_rsp_paddr,
  input  logic [PERM_W-1:0]         tlb_rsp_perm,
  input  logic                      tlb_rsp_miss,
  output logic                      res_valid,
  input  logic                      res_ready,
  output logic [AW-1:0]             res_paddr,
  output logic [PERM_W-1:0]         res_perm,
  output logic                      res_miss
);
  xl_state_e           state_q;
  route_e              route;
  logic [AW-1:0]       seg_paddr;
  logic                dec_itlb;
  logic [1:0]          dec_kind;
  logic                take;

  logic [AW-1:0]       rp_q;
  logic [PERM_W-1:0]   rperm_q;
  logic                rmiss_q;
  logic [AW-1:0]       tva_q;
  logic                titlb_q;
  logic [1:0]          tkind_q;
  logic                tuser_q;

  seg_route_decode #(
    .AW       (AW),
    .SEG_BITS (SEG_BITS),
    .REG_W    (REG_W),
    .KB_W     (KB_W),
    .EN_MASK  (EN_MASK)
  ) u_dec (
    .vaddr      (req_vaddr),
    .kind       (req_kind),
    .user       (req_user),
    .cfg_global (cfg_global),
    .seg_en     (cfg_mmu_seg),
    .kb_lo      (kbase_lo),
    .kb_hi      (kbase_hi),
    .route      (route),
    .seg_paddr  (seg_paddr),
    .itlb       (dec_itlb),
    .fwd_kind   (dec_kind)
  );

  assign take = req_valid && (state_q == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rp_q    <= '0;
      rperm_q <= '0;
      rmiss_q <= 1'b0;
      tva_q   <= '0;
      titlb_q <= 1'b0;
      tkind_q <= 2'd0;
      tuser_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (take) begin
          case (route)
            ROUTE_FLAT: begin
              rp_q    <= req_vaddr;
              rperm_q <= PERM_ALL;
              rmiss_q <= 1'b0;
              state_q <= ST_RESP;
            end
            ROUTE_SEG: begin
              rp_q    <= seg_paddr;
              rperm_q <= PERM_ALL;
              rmiss_q <= 1'b0;
              state_q <= ST_RESP;
            end
            default: begin
              tva_q   <= req_vaddr;
              titlb_q <= dec_itlb;
              tkind_q <= dec_kind;
              tuser_q <= req_user;
              state_q <= ST_TREQ;
            end
          endcase
        end
        ST_TREQ: if (tlb_req_ready) state_q <= ST_TWAIT;
        ST_TWAIT: if (tlb_rsp_valid) begin
          rp_q    <= tlb_rsp_paddr;
          rperm_q <= tlb_rsp_perm;
          rmiss_q <= tlb_rsp_miss;
          state_q <= ST_RESP;
        end
        default: if (res_ready) state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign tlb_req_valid = (state_q == ST_TREQ);
  assign tlb_req_itlb  = titlb_q;
  assign tlb_req_vaddr = tva_q;
  assign tlb_req_kind  = tkind_q;
  assign tlb_req_user  = tuser_q;
  assign res_valid     = (state_q == ST_RESP);
  assign res_paddr     = rp_q;
  assign res_perm      = rperm_q;
  assign res_miss      = rmiss_q;
endmodule

// File: rtl/seg_xlate_front_chk.sv
module seg_xlate_front_chk #(
  parameter int AW       = 32,
  parameter int SEG_BITS = 4,
  parameter int REG_W    = 32,
  parameter logic [REG_W-1:0] EN_MASK = 'hC
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic                     req_ready,
  input logic [AW-1:0]            req_vaddr,
  input logic [1:0]               req_kind,
  input logic                     req_user,
  input logic [REG_W-1:0]         cfg_global,
  input logic [(1<<SEG_BITS)-1:0] cfg_mmu_seg,
  input logic                     tlb_req_valid,
  input logic                     tlb_req_ready,
  input logic                     tlb_req_itlb,
  input logic [AW-1:0]            tlb_req_vaddr,
  input logic                     res_valid,
  input logic                     res_ready,
  input logic [AW-1:0]            res_paddr,
  input logic [2:0]               res_perm,
  input logic                     res_miss
);
  localparam int OFF_W = AW - SEG_BITS;

  logic acc, on;
  assign acc = req_valid && req_ready;
  assign on  = |(cfg_global & EN_MASK);

  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!res_valid && !tlb_req_valid)); // R1

  AST_ONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && tlb_req_valid)); // R1

  AST_FLAT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !on) |=> (res_valid && res_paddr == $past(req_vaddr)
                      && res_perm == 3'b111 && !res_miss)); // R2

  AST_SEG_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && on && !req_user && cfg_mmu_seg[req_vaddr[AW-1 -: SEG_BITS]])
    |=> (res_valid && !res_miss && res_perm == 3'b111
         && res_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0]))); // R5

  AST_USER_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && on && req_user) |=> (tlb_req_valid && tlb_req_vaddr == $past(req_vaddr))); // R6

  AST_EXEC_ITLB: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && on && req_user) |=> (tlb_req_itlb == ($past(req_kind) == 2'd2))); // R7

  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_paddr)
                                   && $stable(res_perm) && $stable(res_miss))); // R9

  AST_TREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tlb_req_valid && !tlb_req_ready) |=> (tlb_req_valid && $stable(tlb_req_vaddr))); // R9
endmodule

bind seg_xlate_front seg_xlate_front_chk #(
  .AW       (AW),
  .SEG_BITS (SEG_BITS),
  .REG_W    (REG_W),
  .EN_MASK  (EN_MASK)
) u_chk (.*);

// File: tb/seg_xlate_front_test.sv
`timescale 1ns/1ps
module seg_xlate_front_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        req_user = 1'b0;
  logic [31:0] cfg_global = '0;
  logic [15:0] cfg_mmu_seg = '0;
  logic [31:0] kbase_lo = '0;
  logic [31:0] kbase_hi = '0;
  logic        tlb_req_valid;
  logic        tlb_req_ready = 1'b0;
  logic        tlb_req_itlb;
  logic [31:0] tlb_req_vaddr;
  logic [1:0]  tlb_req_kind;
  logic        tlb_req_user;
  logic        tlb_rsp_valid = 1'b0;
  logic [31:0] tlb_rsp_paddr = '0;
  logic [2:0]  tlb_rsp_perm = '0;
  logic        tlb_rsp_miss = 1'b0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [31:0] res_paddr;
  logic [2:0]  res_perm;
  logic        res_miss;

  always #2.5 clk = ~clk;

  seg_xlate_front uut (.*);

  typedef struct packed { logic [31:0] paddr; logic [2:0] perm; logic miss; } res_t;
  typedef struct packed { logic [31:0] va; logic itlb; logic [1:0] kind; logic user; } treq_t;

  res_t  exp_q[$];
  treq_t tq[$];
  int    checks = 0;
  int    fails  = 0;
  bit    pend = 0;
  int    dly = 0;
  logic [31:0] pend_va = '0;
  bit    junk = 0;
  bit    done = 0;

  function automatic res_t tlb_answer(input logic [31:0] va);
    res_t r;
    r.paddr = {va[31:13] ^ 19'h2B3C5, va[12:0]};
    r.perm  = va[3:1];
    r.miss  = va[0];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: computes expected outcome from the requirements and applies the request
  task automatic send(input logic [31:0] va, input logic [1:0] k, input logic u,
                      input logic [31:0] g, input logic [15:0] m,
                      input logic [31:0] lo, input logic [31:0] hi);
    bit on, direct;
    logic [3:0] sg, nb;
    logic [31:0] src;
    res_t e;
    treq_t t;
    on = (g[2] | g[3]);
    sg = va[31:28];
    direct = on && !u && m[sg];
    src = (sg < 4'd8) ? lo : hi;
    nb = 4'((src >> ({29'd0, sg[2:0]} * 4)) & 32'hF);
    if (!on) begin
      e.paddr = va; e.perm = 3'b111; e.miss = 1'b0; exp_q.push_back(e);
    end else if (direct) begin
      e.paddr = {nb, va[27:0]}; e.perm = 3'b111; e.miss = 1'b0; exp_q.push_back(e);
    end else begin
      t.va = va; t.itlb = (k == 2'd2); t.kind = (k == 2'd3) ? 2'd0 : k; t.user = u;
      tq.push_back(t);
      exp_q.push_back(tlb_answer(va));
    end
    while (!req_ready) @(negedge clk);
    req_vaddr = va; req_kind = k; req_user = u;
    cfg_global = g; cfg_mmu_seg = m; kbase_lo = lo; kbase_hi = hi;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (!on || direct)  // R2 R5: result one cycle after the request is taken
      chk(res_valid === 1'b1, "R2/R5 result latency", {63'd0, res_valid}, 64'd1);
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || tq.size() != 0 || pend) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Monitor: scoreboard on results, plus hold and readiness checks
  logic        pv = 0, pr = 0;
  logic [31:0] ppa = '0;
  logic [2:0]  ppe = '0;
  logic        pmi = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pv && !pr) begin
        chk(res_valid === 1'b1 && res_paddr === ppa && res_perm === ppe && res_miss === pmi,
            "R9 result hold", {31'd0, res_valid, res_paddr}, {31'd1, ppa});
      end
      if (res_valid || tlb_req_valid)
        chk(req_ready === 1'b0, "R1 ready while busy", {63'd0, req_ready}, 64'd0);
      res_ready = ($urandom % 4) != 0;
      if (res_valid && res_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 unexpected result", {32'd0, res_paddr}, 64'd0);
        end else begin
          res_t e;
          e = exp_q.pop_front();
          chk(res_paddr === e.paddr && res_perm === e.perm && res_miss === e.miss,
              "R2/R5/R8 result", {28'd0, res_perm, res_miss, res_paddr}, {28'd0, e.perm, e.miss, e.paddr});
        end
      end
      pv = res_valid; pr = res_ready; ppa = res_paddr; ppe = res_perm; pmi = res_miss;
    end
  end

  // TLB model: checks routing, answers after a short delay
  logic        tpv = 0, tpr = 0;
  logic [31:0] tpva = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      tlb_rsp_valid = 1'b0;
      if (tpv && !tpr)
        chk(tlb_req_valid === 1'b1 && tlb_req_vaddr === tpva, "R9 lookup hold",
            {32'd0, tlb_req_vaddr}, {32'd0, tpva});
      if (pend) begin
        if (dly == 0) begin
          res_t a;
          a = tlb_answer(pend_va);
          tlb_rsp_valid = 1'b1; tlb_rsp_paddr = a.paddr; tlb_rsp_perm = a.perm; tlb_rsp_miss = a.miss;
          pend = 0;
        end else dly--;
      end else if (junk) begin
        tlb_rsp_valid = 1'b1; tlb_rsp_paddr = 32'hDEAD_BEEF; tlb_rsp_perm = 3'b010; tlb_rsp_miss = 1'b1;
        junk = 0;
      end
      tlb_req_ready = ($urandom % 3) != 0;
      if (tlb_req_valid && tlb_req_ready) begin
        if (tq.size() == 0) begin
          chk(1'b0, "R6 unexpected lookup", {32'd0, tlb_req_vaddr}, 64'd0);
        end else begin
          treq_t t;
          t = tq.pop_front();
          chk(tlb_req_vaddr === t.va && tlb_req_itlb === t.itlb && tlb_req_kind === t.kind
              && tlb_req_user === t.user, "R6/R7 lookup fields",
              {28'd0, tlb_req_itlb, tlb_req_kind, tlb_req_user, tlb_req_vaddr},
              {28'd0, t.itlb, t.kind, t.user, t.va});
          pend = 1; pend_va = tlb_req_vaddr; dly = $urandom % 3;
        end
      end
      tpv = tlb_req_valid; tpr = tlb_req_ready; tpva = tlb_req_vaddr;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset values
    chk(req_ready === 1'b1 && res_valid === 1'b0 && tlb_req_valid === 1'b0, "R10 reset",
        {61'd0, req_ready, res_valid, tlb_req_valid}, 64'h4);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R3: translation off (bits 2,3 clear, other noise bits set)
    send(32'h1234_5678, 2'd0, 1'b0, 32'hFFFF_FFF3, 16'hFFFF, 32'h0, 32'h0);
    send(32'hF000_0001, 2'd2, 1'b1, 32'h0000_0000, 16'hFFFF, 32'h0, 32'h0);
    send(32'h8ABC_DEF0, 2'd1, 1'b0, 32'h8000_0001, 16'h0000, 32'h0, 32'h0);

    // R3/R4/R5: bit 2 alone, bit 3 alone, every segment with distinct bases
    for (int s = 0; s < 16; s++) begin
      send({s[3:0], 28'h0AB_CDEF ^ 28'(s)}, 2'd0, 1'b0, (s % 2) ? 32'h4 : 32'h8,
           16'hFFFF, 32'h7654_3210 ^ 32'h9999_9999, 32'hFEDC_BA98 ^ 32'h1357_9BDF);
    end
    drain();

    // R6: user always goes to TLB; R7 kind routing incl. kind 3
    for (int k = 0; k < 4; k++)
      send(32'h4000_2000 + 32'(k * 16'h1235), 2'(k), 1'b1, 32'h4, 16'hFFFF, 32'h1111_1111, 32'h2222_2222);
    // R6: supervisor with segment bit clear -> TLB
    send(32'h5000_3001, 2'd2, 1'b0, 32'hC, 16'hFFDF, 32'h0, 32'h0);
    send(32'h5000_3003, 2'd3, 1'b0, 32'h8, 16'h0000, 32'h0, 32'h0);
    drain();

    // R8: stray response while idle is ignored
    junk = 1;
    repeat (4) @(negedge clk);
    chk(res_valid === 1'b0, "R8 stray response ignored", {63'd0, res_valid}, 64'd0);
    send(32'h0000_0040, 2'd0, 1'b0, 32'h0, 16'h0, 32'h0, 32'h0);
    drain();

    // Mixed patterns with back-pressure on both sides (R1 R9)
    for (int i = 0; i < 300; i++) begin
      send($urandom, 2'($urandom), 1'($urandom), ($urandom % 5 == 0) ? 32'h0 : $urandom,
           16'($urandom), $urandom, $urandom);
    end
    drain();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule